// File: doc/BRIEF.md
# Three-Mode Timer with Gated Interrupt Flags

This block is a free-running timer that counts one step per enabled clock. Three status flags record events: the count wrapping past its top value, and matches against two byte-wide compare registers. A two-bit mode field sets how those compare registers are used. In narrow mode the counter is one byte wide, and each compare register is an independent match target with its own flag. In wide-compare mode the counter is two bytes wide, and the two registers form one two-byte target. In capture mode the counter is two bytes wide and the register pair stores a snapshot of the count whenever a trigger arrives.

Software programs the block through a byte-wide write port and reads it back through a combinational read port. A flag is cleared either by writing a one to its bit in the flag register or by the acknowledge strobe that is raised when that interrupt is taken. Each of the three interrupt requests is the AND of a global enable, a per-source enable and that source's flag.

Top module: `mode_timer`

## Requirements
- R1: In narrow mode (mode field 0 or 3) the count advances by one on each clock with `cnt_en` high. It keeps the upper byte at zero, goes from 0x00FF to 0x0000, and holds its value while `cnt_en` is low.
- R2: In wide-compare mode (1) and capture mode (2) the count is two bytes wide and goes from 0xFFFF to 0x0000.
- R3: Flag bit 0 (overflow) sets on the edge where an enabled count leaves its top value: 0xFF in the low byte for narrow mode, 0xFFFF for the wide modes.
- R4: In narrow mode, flag bit 1 sets when the low byte of the incremented count equals compare A (address 0). Flag bit 2 sets when it equals compare B (address 1).
- R5: In wide-compare mode, flag bit 1 sets when the incremented two-byte count equals {compare B, compare A}, and flag bit 2 never sets.
- R6: In capture mode, `cap_trig` loads the current count into the pair on the next edge, high byte into B and low byte into A. A capture overrides a host write to either register in the same cycle. Neither compare flag sets in this mode.
- R7: A write to the flag register (address 2) clears each flag whose data bit is one. Flags whose data bit is zero are left unchanged.
- R8: `irq_ack[i]` clears flag i on the next edge.
- R9: If a hardware set and a clear (write or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R10: `irq[i]` is high exactly when `gie`, `irq_en[i]` and flag i are all high.
- R11: After reset all registers and the count read as zero. The read map is: 0 compare A, 1 compare B, 2 flags (bits 7..3 read zero), 3 mode (bits 1..0), 4 count low byte, 5 count high byte, 6 and 7 zero. Writes to addresses 4 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Combinational read data |
| cnt_en | input | 1 | Count enable |
| cap_trig | input | 1 | Capture trigger |
| gie | input | 1 | Global interrupt enable |
| irq_en | input | 3 | Per-source enables: 0 overflow, 1 compare A, 2 compare B |
| irq_ack | input | 3 | Per-source acknowledge strobes |
| irq | output | 3 | Interrupt requests |

## Verification
Every state change (count, compare registers, mode, flags, captured pair) is due on the first rising edge after the inputs that cause it. `rd_data` and `irq` are combinational views of that registered state, so they show the result shortly after the same edge. The bench applies stimulus on the falling edge, advances its own model at the rising edge, and samples the outputs 1 ns later, which gives a one-edge latency for every result. One long directed run in wide-compare mode passes the full two-byte wrap. During that run compare B matches its low byte many times, which confirms that flag bit 2 stays clear.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    MODE_NARROW = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_CAPT   = 2'd2,
    MODE_NALT   = 2'd3
  } mt_mode_e;

  localparam int ADDR_W   = 3;
  localparam int NFLAGS   = 3;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CA  = 1;
  localparam int FLAG_CB  = 2;

  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNTH  = 3'd5;

  function automatic logic mode_is_wide(mt_mode_e m);
    return (m == MODE_WIDE) || (m == MODE_CAPT);
  endfunction
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wide,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next,
  output logic          wrap_evt
);
  function automatic logic [CW-1:0] step(logic [CW-1:0] c, logic w);
    if (w) return c + CW'(1);
    return {{DW{1'b0}}, c[DW-1:0] + DW'(1)};
  endfunction

  function automatic logic at_top(logic [CW-1:0] c, logic w);
    return w ? (&c) : (&c[DW-1:0]);
  endfunction

  assign cnt_next = step(cnt, wide);
  assign wrap_evt = en && at_top(cnt, wide);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt_next;
  end
endmodule

// File: rtl/mt_compare.sv
module mt_compare #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wr_data,
  input  logic          capture,
  input  logic          cnt_en,
  input  logic          wide,
  input  logic          capt_mode,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_next,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic          match_a,
  output logic          match_b
);
  function automatic logic hit_a(logic [CW-1:0] n, logic [DW-1:0] a,
                                 logic [DW-1:0] b, logic w);
    return w ? (n == {b, a}) : (n[DW-1:0] == a);
  endfunction

  assign match_a = cnt_en && !capt_mode && hit_a(cnt_next, reg_a, reg_b, wide);
  assign match_b = cnt_en && !wide && (cnt_next[DW-1:0] == reg_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (capture) begin
      reg_a <= cnt[DW-1:0];
      reg_b <= cnt[CW-1:DW];
    end else begin
      if (wr_a) reg_a <= wr_data;
      if (wr_b) reg_b <= wr_data;
    end
  end
endmodule

// File: rtl/mt_flags.sv
module mt_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/mode_timer.sv
module mode_timer
  import mt_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              cnt_en,
  input  logic              cap_trig,
  input  logic              gie,
  input  logic [NFLAGS-1:0] irq_en,
  input  logic [NFLAGS-1:0] irq_ack,
  output logic [NFLAGS-1:0] irq
);
  mt_mode_e          mode_q;
  logic              wide;
  logic              capt_mode;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nx;
  logic              ovf_evt;
  logic [DW-1:0]     cmpa_q;
  logic [DW-1:0]     cmpb_q;
  logic              mat_a_evt;
  logic              mat_b_evt;
  logic              cap_evt;
  logic [NFLAGS-1:0] flags_q;
  logic [NFLAGS-1:0] flag_set;
  logic [NFLAGS-1:0] flag_clr;
  logic [NFLAGS-1:0] host_clr;

  assign wide      = mode_is_wide(mode_q);
  assign capt_mode = (mode_q == MODE_CAPT);
  assign cap_evt   = cap_trig && capt_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)                            mode_q <= MODE_NARROW;
    else if (wr_en && wr_addr == A_MODE)   mode_q <= mt_mode_e'(wr_data[1:0]);
  end

  mt_counter #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cnt_en),
    .wide     (wide),
    .cnt      (cnt_q),
    .cnt_next (cnt_nx),
    .wrap_evt (ovf_evt)
  );

  mt_compare #(.DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_a      (wr_en && wr_addr == A_CMPA),
    .wr_b      (wr_en && wr_addr == A_CMPB),
    .wr_data   (wr_data),
    .capture   (cap_evt),
    .cnt_en    (cnt_en),
    .wide      (wide),
    .capt_mode (capt_mode),
    .cnt       (cnt_q),
    .cnt_next  (cnt_nx),
    .reg_a     (cmpa_q),
    .reg_b     (cmpb_q),
    .match_a   (mat_a_evt),
    .match_b   (mat_b_evt)
  );

  assign host_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NFLAGS-1:0] : '0;
  assign flag_clr = host_clr | irq_ack;

  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_OVF] = ovf_evt;
    flag_set[FLAG_CA]  = mat_a_evt;
    flag_set[FLAG_CB]  = mat_b_evt;
  end

  mt_flags #(.NF(NFLAGS)) u_flg (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flags_q)
  );

  assign irq = flags_q & irq_en & {NFLAGS{gie}};

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CMPA:  rd_data = cmpa_q;
      A_CMPB:  rd_data = cmpb_q;
      A_FLAGS: rd_data[NFLAGS-1:0] = flags_q;
      A_MODE:  rd_data[1:0] = mode_q;
      A_CNTL:  rd_data = cnt_q[DW-1:0];
      A_CNTH:  rd_data = cnt_q[CW-1:DW];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/mt_chk.sv
module mt_chk #(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          cap_trig,
  input logic          gie,
  input logic [2:0]    irq,
  input logic [2:0]    irq_ack,
  input logic [1:0]    mode,
  input logic          wide,
  input logic [CW-1:0] cnt_q,
  input logic [DW-1:0] cmpa_q,
  input logic [DW-1:0] cmpb_q,
  input logic [2:0]    flags_q,
  input logic          ovf_evt,
  input logic          mat_a_evt,
  input logic          mat_b_evt
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  p_wrap8_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && cnt_en && (&cnt_q[DW-1:0])) |=> (cnt_q == '0));

  p_wrap16_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && cnt_en && (&cnt_q)) |=> (cnt_q == '0));

  p_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags_q[0]);

  p_match_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mat_b_evt |=> flags_q[2]);

  p_no_b_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !$rose(flags_q[2]));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_trig && mode == 2'd2) |=> ({cmpb_q, cmpa_q} == $past(cnt_q)));

  p_capt_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (!$rose(flags_q[1]) && !$rose(flags_q[2])));

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack[0] && !ovf_evt) |=> !flags_q[0]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mat_a_evt |=> flags_q[1]);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == 3'b000));
endmodule

bind mode_timer mt_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .cap_trig  (cap_trig),
  .gie       (gie),
  .irq       (irq),
  .irq_ack   (irq_ack),
  .mode      (mode_q),
  .wide      (wide),
  .cnt_q     (cnt_q),
  .cmpa_q    (cmpa_q),
  .cmpb_q    (cmpb_q),
  .flags_q   (flags_q),
  .ovf_evt   (ovf_evt),
  .mat_a_evt (mat_a_evt),
  .mat_b_evt (mat_b_evt)
);

// File: tb/mode_timer_tb.sv
`timescale 1ns/100ps
module mode_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       cnt_en = 1'b0;
  logic       cap_trig = 1'b0;
  logic       gie = 1'b0;
  logic [2:0] irq_en = '0;
  logic [2:0] irq_ack = '0;
  logic [2:0] irq;

  always #2 clk = ~clk;

  mode_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_en(cnt_en), .cap_trig(cap_trig),
    .gie(gie), .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq)
  );

  int errs = 0;
  int checks = 0;
  logic done = 1'b0;

  // bench model of the state seen through the ports
  logic [15:0] m_cnt = '0;
  logic [7:0]  m_a = '0, m_b = '0;
  logic [2:0]  m_f = '0;
  logic [1:0]  m_mode = '0;

  function automatic logic two_byte(logic [1:0] md);
    return md == 2'd1 || md == 2'd2;
  endfunction

  function automatic logic [7:0] expect_rd(logic [2:0] ad);
    case (ad)
      3'd0: return m_a;
      3'd1: return m_b;
      3'd2: return {5'b0, m_f};
      3'd3: return {6'b0, m_mode};
      3'd4: return m_cnt[7:0];
      3'd5: return m_cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_for(logic [2:0] ad);
    case (ad)
      3'd0, 3'd1: return "R6 compare/capture pair";
      3'd2: return "R3/R4/R5/R7/R8/R9 flags";
      3'd3: return "R11 mode";
      3'd4, 3'd5: return two_byte(m_mode) ? "R2 count" : "R1 count";
      default: return "R11 unmapped";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already set by caller; drive change at negedge happened
  task automatic tick();
    logic        w;
    logic [15:0] inc, n_cnt;
    logic        s_o, s_a, s_b;
    logic [2:0]  clr, n_f;
    logic [7:0]  n_a, n_b;
    logic [1:0]  n_mode;
    w   = two_byte(m_mode);
    inc = w ? m_cnt + 16'd1 : {8'h00, m_cnt[7:0] + 8'd1};
    s_o = cnt_en && (w ? (m_cnt == 16'hFFFF) : (m_cnt[7:0] == 8'hFF));
    s_a = cnt_en && (m_mode != 2'd2) && (w ? (inc == {m_b, m_a}) : (inc[7:0] == m_a));
    s_b = cnt_en && !w && (inc[7:0] == m_b);
    clr = irq_ack | ((wr_en && wr_addr == 3'd2) ? wr_data[2:0] : 3'b000);
    n_f = (m_f & ~clr) | {s_b, s_a, s_o};
    n_a = (wr_en && wr_addr == 3'd0) ? wr_data : m_a;
    n_b = (wr_en && wr_addr == 3'd1) ? wr_data : m_b;
    if (cap_trig && m_mode == 2'd2) begin
      n_a = m_cnt[7:0];
      n_b = m_cnt[15:8];
    end
    n_mode = (wr_en && wr_addr == 3'd3) ? wr_data[1:0] : m_mode;
    n_cnt  = cnt_en ? inc : m_cnt;
    @(posedge clk);
    m_cnt = n_cnt; m_a = n_a; m_b = n_b; m_f = n_f; m_mode = n_mode;
    #1;
    check(tag_for(rd_addr), {8'h00, rd_data}, {8'h00, expect_rd(rd_addr)});
    check("R10 irq gating", {13'b0, irq}, {13'b0, m_f & irq_en & {3{gie}}});
    @(negedge clk);
    wr_en = 1'b0; irq_ack = '0; cap_trig = 1'b0;
  endtask

  task automatic host_wr(logic [2:0] ad, logic [7:0] d);
    wr_en = 1'b1; wr_addr = ad; wr_data = d;
    tick();
  endtask

  initial begin
    #(190000 * 4);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state at every address
    for (int ad = 0; ad < 8; ad++) begin
      rd_addr = 3'(ad);
      tick();
    end
    gie = 1'b1; irq_en = 3'b111;
    // R11 writes to count address ignored
    host_wr(3'd4, 8'h55);
    rd_addr = 3'd4;
    tick();
    check("R11 count not writable", {8'h00, rd_data}, 16'h0000);

    // R4 narrow compares, R1/R3 wrap
    host_wr(3'd0, 8'h10);
    host_wr(3'd1, 8'h20);
    cnt_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      rd_addr = (i % 2 == 0) ? 3'd2 : 3'd4;
      tick();
    end
    // R9 set beats clear: stop one before the A match
    host_wr(3'd2, 8'h07);
    while (m_cnt[7:0] != 8'h0F) tick();
    rd_addr = 3'd2;
    irq_ack = 3'b010; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h02;
    tick();
    check("R9 set wins over clear", {8'h00, rd_data[1], 7'b0}, 16'h0080);
    cnt_en = 1'b0;
    // R7 writing zeros keeps the flag
    host_wr(3'd2, 8'h00);
    check("R7 zero write keeps flag", {15'b0, rd_data[1]}, 16'h0001);
    // R8 ack clears
    irq_ack = 3'b010;
    tick();
    check("R8 ack clears", {15'b0, rd_data[1]}, 16'h0000);

    // R5 / R2 wide compare through the full wrap
    host_wr(3'd3, 8'h01);
    host_wr(3'd0, 8'h30);
    host_wr(3'd1, 8'h01);
    host_wr(3'd2, 8'h07);
    cnt_en = 1'b1;
    for (int i = 0; i < 65700; i++) begin
      rd_addr = (i % 3 == 0) ? 3'd2 : ((i % 3 == 1) ? 3'd4 : 3'd5);
      tick();
    end
    check("R5 flag B never set", {15'b0, m_f[2]}, 16'h0000);

    // R6 capture, capture beats write
    host_wr(3'd3, 8'h02);
    rd_addr = 3'd0;
    cap_trig = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hA5;
    tick();
    rd_addr = 3'd1;
    tick();

    // mixed random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cnt_en   = (r[1:0] != 2'b00);
      cap_trig = (r[6:2] == 5'd0);
      gie      = (r[9:7] != 3'd0);
      if (r[12:10] == 3'd0) irq_en = r[15:13];
      irq_ack  = (r[19:16] == 4'd0) ? r[22:20] : 3'b000;
      rd_addr  = r[25:23];
      if (r[28:26] == 3'd0) begin
        wr_en   = 1'b1;
        wr_addr = r[31:29];
        wr_data = 8'($urandom);
        if (wr_addr == 3'd3 && ($urandom % 4) != 0) wr_addr = 3'd2;
      end
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule